// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block sequences the calibration of a sampling converter and corrects its raw conversion words. A rising edge on the calibration strobe latches a two-bit routine selector. The chosen routine then runs for its own fixed number of master clock cycles. During that window, each measurement-done pulse from the modulator model loads the next pending calibration point into the zero-point or full-point coefficient register. The routine decides which registers are pending, and in what order they load.

Outside a routine, every raw word accepted on the input stream is corrected against the two stored points and saturated, then presented on a one-stage output stream. In unipolar mode the zero point maps to code 0 and the full point maps to code 65535. In bipolar mode the zero point is the midscale point and maps to code 32768, and the full point maps to 65535. The output is offset binary.

While a routine runs, input words are accepted and discarded, and no output is presented. A new strobe edge during a routine restarts the count with the newly selected routine.

Top module: `cal_sequencer`

## Requirements
- R1: The selector `cal_sel` is sampled only in the cycle in which `cal_strobe` is first seen high. Changes to `cal_sel` later in the routine do not change the routine or its length.
- R2: `busy` rises on the clock edge that detects the strobe rise and stays high for exactly the selected routine's cycle count. The selector codes are 2'b00 for the full self routine (SELF_CYCLES), 2'b11 for system offset (OFF_CYCLES), 2'b01 for system gain (GAIN_CYCLES), and 2'b10 for system offset with reference gain (OG_CYCLES).
- R3: Measurement loading depends on the routine. Routines 2'b00 and 2'b10 load `meas_data` into the zero point on their first `meas_done` pulse and into the full point on their second. Routine 2'b11 loads only the zero point, and routine 2'b01 loads only the full point. Any further pulse, and any `meas_done` pulse while idle, has no effect.
- R4: In unipolar mode (`bipolar`=0), an accepted raw word r with zero < r < full produces floor((r-zero)*65535/(full-zero)).
- R5: In bipolar mode (`bipolar`=1), an accepted raw word r with zero <= r < full produces 32768 + floor((r-zero)*32767/(full-zero)). An accepted raw word r below zero produces 32768 - floor((zero-r)*32768/(full-zero)), or 0 when that difference reaches 32768.
- R6: A raw word at or above the full point produces 16'hFFFF. In unipolar mode, a raw word at or below the zero point produces 16'h0000.
- R7: While `busy` is high, `out_valid` is low from the second busy cycle on, and words accepted during the routine produce no output. The first word accepted after `busy` falls produces an output.
- R8: A strobe rise while `busy` is high restarts the routine from its first cycle with the new selector. `busy` then lasts the new routine's full count from that edge.
- R9: The output stream follows valid/ready. `raw_ready` is high whenever `out_valid` is low or `out_ready` is high. A presented word holds `out_valid` and a stable `out_data` until `out_ready` takes it.
- R10: After reset, `busy` and `out_valid` are low, the zero point is 0 and the full point is 65535, so unipolar correction passes raw words through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_strobe | input | 1 | Calibration strobe, acts on its rising edge |
| cal_sel | input | 2 | Routine selector |
| bipolar | input | 1 | 1 selects bipolar correction, 0 selects unipolar |
| meas_done | input | 1 | Measurement-complete pulse from the modulator model |
| meas_data | input | W | Measured calibration point |
| raw_valid | input | 1 | Raw word valid |
| raw_ready | output | 1 | Raw word accepted when high with raw_valid |
| raw_data | input | W | Raw conversion word |
| out_valid | output | 1 | Corrected word present (data ready) |
| out_ready | input | 1 | Downstream takes the corrected word |
| out_data | output | W | Corrected, saturated word |
| busy | output | 1 | A calibration routine is running |

## Verification
A corrected word appears on `out_valid` one cycle after its raw word is accepted. The driver pushes the expected value when it drives the word, and the monitor compares at the falling edge after the accepting edge, on each handshake. `busy` is due on the edge that sees the strobe high and lasts the routine count. The bench counts falling edges with `busy` high, starting at the first falling edge after that edge. Coefficient loads are checked one cycle after each measurement pulse, through the outputs of later corrected words.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    CAL_SELF     = 2'b00,
    CAL_SYS_GAIN = 2'b01,
    CAL_SYS_OG   = 2'b10,
    CAL_SYS_OFF  = 2'b11
  } cal_sel_e;

  // Which coefficient a routine still has to load.
  typedef struct packed {
    logic zero;
    logic full;
  } cal_pend_t;
endpackage

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_pkg::*;
#(
  parameter int unsigned SELF_CYCLES = 3145655,
  parameter int unsigned OFF_CYCLES  = 1052599,
  parameter int unsigned GAIN_CYCLES = 1068813,
  parameter int unsigned OG_CYCLES   = 2117389
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_strobe,
  input  logic [1:0] cal_sel,
  input  logic       meas_done,
  output logic       busy,
  output logic       load_zero,
  output logic       load_full
);
  localparam int unsigned MAX_AB = (SELF_CYCLES > OFF_CYCLES) ? SELF_CYCLES : OFF_CYCLES;
  localparam int unsigned MAX_CD = (GAIN_CYCLES > OG_CYCLES) ? GAIN_CYCLES : OG_CYCLES;
  localparam int unsigned MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             strobe_q;
  logic             start;
  cal_sel_e         routine_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  cal_pend_t        pend_q;
  cal_pend_t        pend_init;

  assign start = cal_strobe && !strobe_q;

  always_comb begin
    unique case (routine_q)
      CAL_SELF:     last_cnt = CNT_W'(SELF_CYCLES - 1);
      CAL_SYS_OFF:  last_cnt = CNT_W'(OFF_CYCLES - 1);
      CAL_SYS_GAIN: last_cnt = CNT_W'(GAIN_CYCLES - 1);
      default:      last_cnt = CNT_W'(OG_CYCLES - 1);
    endcase
  end

  always_comb begin
    unique case (cal_sel_e'(cal_sel))
      CAL_SYS_OFF:  pend_init = '{zero: 1'b1, full: 1'b0};
      CAL_SYS_GAIN: pend_init = '{zero: 1'b0, full: 1'b1};
      default:      pend_init = '{zero: 1'b1, full: 1'b1};
    endcase
  end

  assign load_zero = busy && !start && meas_done && pend_q.zero;
  assign load_full = busy && !start && meas_done && !pend_q.zero && pend_q.full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      busy      <= 1'b0;
      routine_q <= CAL_SELF;
      cnt_q     <= '0;
      pend_q    <= '0;
    end else begin
      strobe_q <= cal_strobe;
      if (start) begin
        busy      <= 1'b1;
        routine_q <= cal_sel_e'(cal_sel);
        cnt_q     <= '0;
        pend_q    <= pend_init;
      end else if (busy) begin
        if (cnt_q == last_cnt) begin
          busy   <= 1'b0;
          pend_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (load_zero) pend_q.zero <= 1'b0;
        if (load_full) pend_q.full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cal_coeff_regs.sv
module cal_coeff_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_zero,
  input  logic         load_full,
  input  logic [W-1:0] meas_data,
  output logic [W-1:0] zero_pt,
  output logic [W-1:0] full_pt
);
  localparam int NCOEF = 2;

  logic [NCOEF-1:0] load;
  logic [W-1:0]     coef [NCOEF];

  assign load = {load_full, load_zero};

  for (genvar i = 0; i < NCOEF; i++) begin : g_coef
    // Index 0 resets to the bottom code, index 1 to the top code.
    localparam logic [W-1:0] RST_VAL = (i == 0) ? '0 : '1;
    always_ff @(posedge clk) begin
      if (!rst_n)       coef[i] <= RST_VAL;
      else if (load[i]) coef[i] <= meas_data;
    end
  end

  assign zero_pt = coef[0];
  assign full_pt = coef[1];
endmodule

// File: rtl/cal_correct.sv
module cal_correct #(
  parameter int W = 16
) (
  input  logic         bipolar,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] zero_pt,
  input  logic [W-1:0] full_pt,
  output logic [W-1:0] result
);
  localparam int PW = 2 * W + 2;
  localparam logic [PW-1:0] TOP  = PW'((64'd1 << W) - 1);
  localparam logic [PW-1:0] MID  = PW'(64'd1 << (W - 1));
  localparam logic [PW-1:0] HALF = MID - 1'b1;

  logic [W-1:0]  den, above, below;
  logic [PW-1:0] q_uni, q_up, q_dn;

  assign den   = (full_pt > zero_pt) ? (full_pt - zero_pt) : W'(1);
  assign above = raw - zero_pt;
  assign below = zero_pt - raw;

  assign q_uni = (PW'(above) * TOP) / PW'(den);
  assign q_up  = (PW'(above) * HALF) / PW'(den);
  assign q_dn  = (PW'(below) * MID) / PW'(den);

  always_comb begin
    if (raw >= full_pt) begin
      result = '1;
    end else if (!bipolar) begin
      if (raw <= zero_pt)  result = '0;
      else if (q_uni > TOP) result = '1;
      else                 result = q_uni[W-1:0];
    end else if (raw >= zero_pt) begin
      result = (q_up > HALF) ? '1 : W'(MID + q_up);
    end else begin
      result = (q_dn >= MID) ? '0 : W'(MID - q_dn);
    end
  end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int          W           = 16,
  parameter int unsigned SELF_CYCLES = 3145655,
  parameter int unsigned OFF_CYCLES  = 1052599,
  parameter int unsigned GAIN_CYCLES = 1068813,
  parameter int unsigned OG_CYCLES   = 2117389
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cal_strobe,
  input  logic [1:0]   cal_sel,
  input  logic         bipolar,
  input  logic         meas_done,
  input  logic [W-1:0] meas_data,
  input  logic         raw_valid,
  output logic         raw_ready,
  input  logic [W-1:0] raw_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         busy
);
  logic         load_zero, load_full;
  logic [W-1:0] zero_q, full_q, corr;
  logic         accept;

  cal_seq_ctrl #(
    .SELF_CYCLES(SELF_CYCLES), .OFF_CYCLES(OFF_CYCLES),
    .GAIN_CYCLES(GAIN_CYCLES), .OG_CYCLES(OG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cal_strobe(cal_strobe), .cal_sel(cal_sel),
    .meas_done(meas_done), .busy(busy), .load_zero(load_zero), .load_full(load_full)
  );

  cal_coeff_regs #(.W(W)) u_coef (
    .clk(clk), .rst_n(rst_n), .load_zero(load_zero), .load_full(load_full),
    .meas_data(meas_data), .zero_pt(zero_q), .full_pt(full_q)
  );

  cal_correct #(.W(W)) u_corr (
    .bipolar(bipolar), .raw(raw_data), .zero_pt(zero_q), .full_pt(full_q), .result(corr)
  );

  assign raw_ready = !out_valid || out_ready;
  assign accept    = raw_valid && raw_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (busy) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= corr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk #(
  parameter int          W           = 16,
  parameter int unsigned SELF_CYCLES = 3145655,
  parameter int unsigned OFF_CYCLES  = 1052599,
  parameter int unsigned GAIN_CYCLES = 1068813,
  parameter int unsigned OG_CYCLES   = 2117389
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cal_strobe,
  input logic [1:0]   cal_sel,
  input logic         bipolar,
  input logic         raw_valid,
  input logic         raw_ready,
  input logic [W-1:0] raw_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         busy,
  input logic [W-1:0] zero_w,
  input logic [W-1:0] full_w
);
  logic        stb_prev;
  logic [1:0]  sel_seen;
  logic [31:0] run_len;
  logic [31:0] want_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_prev <= 1'b0;
      sel_seen <= 2'b00;
      run_len  <= '0;
    end else begin
      stb_prev <= cal_strobe;
      if (cal_strobe && !stb_prev) begin
        sel_seen <= cal_sel;
        run_len  <= '0;
      end else if (busy) begin
        run_len <= run_len + 1;
      end
    end
  end

  always_comb begin
    case (sel_seen)
      2'b00:   want_len = SELF_CYCLES;
      2'b11:   want_len = OFF_CYCLES;
      2'b01:   want_len = GAIN_CYCLES;
      default: want_len = OG_CYCLES;
    endcase
  end

  // R2 and R8: busy length from the latest strobe edge
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == want_len);

  p_quiet_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> !out_valid);

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !busy |=> out_valid && $stable(out_data));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> raw_ready);

  p_sat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid && raw_ready && !busy && raw_data >= full_w |=> out_data == '1);

  p_sat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid && raw_ready && !busy && !bipolar && raw_data <= zero_w && raw_data < full_w
    |=> out_data == '0);
endmodule

bind cal_sequencer cal_sequencer_chk #(
  .W(W), .SELF_CYCLES(SELF_CYCLES), .OFF_CYCLES(OFF_CYCLES),
  .GAIN_CYCLES(GAIN_CYCLES), .OG_CYCLES(OG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_strobe(cal_strobe), .cal_sel(cal_sel),
  .bipolar(bipolar), .raw_valid(raw_valid), .raw_ready(raw_ready),
  .raw_data(raw_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .busy(busy), .zero_w(zero_q), .full_w(full_q)
);

// File: tb/cal_sequencer_tb.sv
module cal_sequencer_tb;
  localparam int W = 16;
  localparam int unsigned T_SELF = 40, T_OFF = 20, T_GAIN = 24, T_OG = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cal_strobe = 1'b0, bipolar = 1'b0, meas_done = 1'b0;
  logic [1:0] cal_sel = 2'b00;
  logic [W-1:0] meas_data = '0, raw_data = '0;
  logic raw_valid = 1'b0, out_ready = 1'b1;
  logic raw_ready, out_valid, busy;
  logic [W-1:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;
  int unsigned m_zero = 0, m_full = 65535;
  logic [W-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  cal_sequencer #(.W(W), .SELF_CYCLES(T_SELF), .OFF_CYCLES(T_OFF),
    .GAIN_CYCLES(T_GAIN), .OG_CYCLES(T_OG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_strobe(cal_strobe), .cal_sel(cal_sel),
    .bipolar(bipolar), .meas_done(meas_done), .meas_data(meas_data),
    .raw_valid(raw_valid), .raw_ready(raw_ready), .raw_data(raw_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .busy(busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned model(input int unsigned r, input bit bip);
    int unsigned den, d;
    den = (m_full > m_zero) ? m_full - m_zero : 1;
    if (r >= m_full) return 65535;
    if (!bip) begin
      if (r <= m_zero) return 0;
      return ((r - m_zero) * 65535) / den;
    end
    if (r >= m_zero) return 32768 + ((r - m_zero) * 32767) / den;
    d = ((m_zero - r) * 32768) / den;
    return (d >= 32768) ? 0 : 32768 - d;
  endfunction

  // scoreboard monitor: a handshake is seen at the falling edge after it forms
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected word", int'(out_data), -1);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R4/R5/R6 corrected word", int'(out_data), int'(e));
      end
    end
  end

  task automatic send(input int unsigned r);
    @(negedge clk);
    raw_valid = 1'b1;
    raw_data  = W'(r);
    exp_q.push_back(W'(model(r, bipolar)));
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 all words delivered", exp_q.size(), 0);
  endtask

  // strobe, then count busy cycles with measurements and a discarded word inside
  task automatic run_cal(input logic [1:0] sel, input int unsigned want,
                         input int nm, input int unsigned m0, input int unsigned m1);
    int n;
    @(negedge clk);
    cal_sel = sel;
    cal_strobe = 1'b1;
    @(negedge clk);
    cal_strobe = 1'b0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      meas_done = 1'b0;
      raw_valid = 1'b0;
      if (n > 1 && out_valid) check(1'b0, "R7 out_valid during busy", 1, 0);
      if (n == 3 && nm > 0) begin meas_done = 1'b1; meas_data = W'(m0); end
      if (n == 4) cal_sel = ~sel;             // R1: late selector change
      if (n == 6 && nm > 1) begin meas_done = 1'b1; meas_data = W'(m1); end
      if (n == 8) begin raw_valid = 1'b1; raw_data = 16'd777; end
      if (n == 10) begin meas_done = 1'b1; meas_data = 16'd4242; end // extra pulse, no effect
      @(negedge clk);
    end
    meas_done = 1'b0;
    raw_valid = 1'b0;
    check(n == int'(want), "R1/R2 busy length", n, int'(want));
    case (sel)
      2'b00, 2'b10: begin m_zero = m0; m_full = m1; end
      2'b11: m_zero = m0;
      default: m_full = m0;
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R10 busy after reset", busy, 0);
    check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    check(raw_ready == 1'b1, "R9 ready when empty", raw_ready, 1);

    // R10 pass-through with reset coefficients
    send(0); send(12345); send(65535);
    drain();

    // R2/R3 self routine, then R4/R6 unipolar words
    run_cal(2'b00, T_SELF, 2, 1000, 61000);
    send(31000); send(1000); send(500); send(61000); send(65000); send(20000);
    drain();

    // R5 bipolar with the same points
    bipolar = 1'b1;
    send(31000); send(46000); send(10000); send(0);
    drain();

    // R3 two-step system routine: offset then gain
    run_cal(2'b11, T_OFF, 1, 33000, 0);
    run_cal(2'b01, T_GAIN, 1, 63000, 0);
    send(2000); send(48000); send(20000); send(63000); send(33000);
    drain();

    // R3 offset plus reference gain, unipolar
    bipolar = 1'b0;
    run_cal(2'b10, T_OG, 2, 500, 40000);
    send(500); send(20250); send(39999); send(40000);
    drain();

    // R3 measurement pulse while idle is ignored
    @(negedge clk);
    meas_done = 1'b1; meas_data = 16'd30000;
    @(negedge clk);
    meas_done = 1'b0;
    send(30000); send(501);
    drain();

    // R8 restart: begin offset routine, restart with gain routine
    @(negedge clk);
    cal_sel = 2'b11; cal_strobe = 1'b1;
    @(negedge clk);
    cal_strobe = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b1, "R8 busy before restart", busy, 1);
    run_cal(2'b01, T_GAIN, 1, 50000, 0);
    send(25250); send(49999);
    drain();

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    raw_valid = 1'b1; raw_data = 16'd10000;
    exp_q.push_back(W'(model(10000, 1'b0)));
    @(negedge clk);
    raw_valid = 1'b0;
    check(out_valid == 1'b1, "R9 word presented", out_valid, 1);
    check(raw_ready == 1'b0, "R9 ready low while stalled", raw_ready, 0);
    begin
      logic [W-1:0] held;
      held = out_data;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b1 && out_data == held, "R9 word held", int'(out_data), int'(held));
    end
    out_ready = 1'b1;
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule